// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines into one raw-level register. It drives two outputs from that register: a normal request and a fast request. Each output has its own enable mask. Software changes a mask one bit at a time: one address sets the bits written as 1, and another address clears them. Raw bit 0 is shared between hardware line 0 and software. Two dedicated addresses let software force that bit high or low, so a core can raise an interrupt for itself. Controllers can be chained by wiring one controller's request output into an input line of another.

The register port is a plain word-offset bus with no stall. A write strobe completes in the cycle it is presented. A read strobe returns its data on `bus_rdata` one clock later, and `bus_rdata` holds that value until the next read. Because nothing is streamed and there is no back-pressure, the bus has no valid/ready handshake.

Each hardware line is sampled every cycle. The raw bit moves to the line's new level only when the line changes. This lets a software-forced bit 0 persist while line 0 holds still. Both request outputs are registered from the next-cycle state. An input change, or a mask or software write, therefore shows up on the outputs exactly one clock edge later.

Top module: `irqc_dual`

## Requirements
- R1: While reset is asserted, and after it is released, the raw level, both masks, `irq_o`, `fiq_o` and `bus_rdata` are zero.
- R2: `irq_o` is high exactly when (raw level AND normal mask) is nonzero. It reflects any input change or write one clock edge after that change or write is presented.
- R3: `fiq_o` is high exactly when (raw level AND fast mask) is nonzero, with the same one-edge timing as R2.
- R4: A read strobe at word offset 0 returns raw AND normal mask. Offsets 1 and 9 return the raw level. Offset 2 returns the normal mask. Offset 4 returns raw bit 0 in bit 0, with all other bits zero. Offset 8 returns raw AND fast mask. Offset 10 returns the fast mask. The data appears on `bus_rdata` after the next clock edge and shows the state from before any write at that same edge.
- R5: A write to offset 2 ORs `bus_wdata` into the normal mask, and a write to offset 3 clears the mask bits that are 1 in `bus_wdata`. Offsets 10 and 11 do the same for the fast mask.
- R6: A write to offset 4 with `bus_wdata[0]`=1 sets raw bit 0, and a write to offset 5 with `bus_wdata[0]`=1 clears it. When `bus_wdata[0]`=0, either write changes nothing, and bits 31..1 are ignored.
- R7: Reads of offsets 3, 5 and 11, and reads of any offset not listed in R4, return zero. Writes to offsets 0, 1, 8 and 9, and to any offset not listed in R5 or R6, change no state.
- R8: When a hardware line changes level, its raw bit takes the new level. While the line holds still, its raw bit is left as it is.
- R9: If line 0 changes in the same cycle as a software set or clear of bit 0, the software action decides the new value of raw bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_LINES | Level-sensitive interrupt lines |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is raw bit 0 when its two owners disagree. A software set must survive while line 0 stays low. When line 0 and a software write move in opposite directions in the same cycle, the software write must take precedence. The vector table covers both. It first forces bit 0 with a write and then changes other lines. It then has entries where the line field toggles bit 0 and the same entry writes the opposite software action. The result is read back at offset 4 and checked on `irq_o`.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Word offsets; software decodes these, so their values are fixed.
  localparam int unsigned OFS_NRM_STAT = 0;
  localparam int unsigned OFS_RAW_A    = 1;
  localparam int unsigned OFS_NRM_SET  = 2;
  localparam int unsigned OFS_NRM_CLR  = 3;
  localparam int unsigned OFS_SW_SET   = 4;
  localparam int unsigned OFS_SW_CLR   = 5;
  localparam int unsigned OFS_FST_STAT = 8;
  localparam int unsigned OFS_RAW_B    = 9;
  localparam int unsigned OFS_FST_SET  = 10;
  localparam int unsigned OFS_FST_CLR  = 11;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_NRM_STAT,
    RSEL_RAW,
    RSEL_NRM_MASK,
    RSEL_SW_BIT,
    RSEL_FST_STAT,
    RSEL_FST_MASK
  } rsel_e;

  typedef struct packed {
    logic nrm_set;
    logic nrm_clr;
    logic fst_set;
    logic fst_clr;
    logic sw_set;
    logic sw_clr;
  } wstb_t;

endpackage

// File: rtl/irqc_line_sync.sv
module irqc_line_sync #(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] rise_o,
  output logic [NUM_LINES-1:0] fall_o
);

  logic [NUM_LINES-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= line_i;
  end

  // A level change relative to the last sampled value is an update event.
  always_comb begin
    rise_o = line_i & ~seen_q;
    fall_o = ~line_i & seen_q;
  end

endmodule

// File: rtl/irqc_bus_decode.sv
module irqc_bus_decode
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wstb_t             wstb_o,
  output rsel_e             rsel_o
);

  always_comb begin
    wstb_o         = '0;
    wstb_o.nrm_set = wr_i && (addr_i == ADDR_W'(OFS_NRM_SET));
    wstb_o.nrm_clr = wr_i && (addr_i == ADDR_W'(OFS_NRM_CLR));
    wstb_o.fst_set = wr_i && (addr_i == ADDR_W'(OFS_FST_SET));
    wstb_o.fst_clr = wr_i && (addr_i == ADDR_W'(OFS_FST_CLR));
    wstb_o.sw_set  = wr_i && (addr_i == ADDR_W'(OFS_SW_SET));
    wstb_o.sw_clr  = wr_i && (addr_i == ADDR_W'(OFS_SW_CLR));
  end

  always_comb begin
    rsel_o = RSEL_NONE;
    if (rd_i) begin
      if      (addr_i == ADDR_W'(OFS_NRM_STAT)) rsel_o = RSEL_NRM_STAT;
      else if (addr_i == ADDR_W'(OFS_RAW_A))    rsel_o = RSEL_RAW;
      else if (addr_i == ADDR_W'(OFS_RAW_B))    rsel_o = RSEL_RAW;
      else if (addr_i == ADDR_W'(OFS_NRM_SET))  rsel_o = RSEL_NRM_MASK;
      else if (addr_i == ADDR_W'(OFS_SW_SET))   rsel_o = RSEL_SW_BIT;
      else if (addr_i == ADDR_W'(OFS_FST_STAT)) rsel_o = RSEL_FST_STAT;
      else if (addr_i == ADDR_W'(OFS_FST_SET))  rsel_o = RSEL_FST_MASK;
    end
  end

endmodule

// File: rtl/irqc_state.sv
module irqc_state
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  wstb_t                wstb_i,
  input  logic [NUM_LINES-1:0] wbits_i,
  input  logic [NUM_LINES-1:0] rise_i,
  input  logic [NUM_LINES-1:0] fall_i,
  output logic [NUM_LINES-1:0] raw_o,
  output logic [NUM_LINES-1:0] nrm_mask_o,
  output logic [NUM_LINES-1:0] fst_mask_o,
  output logic                 irq_o,
  output logic                 fiq_o
);

  logic [NUM_LINES-1:0] raw_q, raw_nx;
  logic [NUM_LINES-1:0] nrm_q, nrm_nx;
  logic [NUM_LINES-1:0] fst_q, fst_nx;
  logic                 irq_q, fiq_q;

  // Raw level: bit 0 has a software owner that overrides the hardware line.
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_raw
    if (i == 0) begin : g_soft
      always_comb begin
        if (wstb_i.sw_set && wbits_i[0])      raw_nx[i] = 1'b1;
        else if (wstb_i.sw_clr && wbits_i[0]) raw_nx[i] = 1'b0;
        else if (rise_i[i])                   raw_nx[i] = 1'b1;
        else if (fall_i[i])                   raw_nx[i] = 1'b0;
        else                                  raw_nx[i] = raw_q[i];
      end
    end else begin : g_hard
      always_comb begin
        if (rise_i[i])      raw_nx[i] = 1'b1;
        else if (fall_i[i]) raw_nx[i] = 1'b0;
        else                raw_nx[i] = raw_q[i];
      end
    end
  end

  always_comb begin
    nrm_nx = nrm_q;
    if (wstb_i.nrm_set) nrm_nx = nrm_nx | wbits_i;
    if (wstb_i.nrm_clr) nrm_nx = nrm_nx & ~wbits_i;
    fst_nx = fst_q;
    if (wstb_i.fst_set) fst_nx = fst_nx | wbits_i;
    if (wstb_i.fst_clr) fst_nx = fst_nx & ~wbits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      nrm_q <= '0;
      fst_q <= '0;
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      raw_q <= raw_nx;
      nrm_q <= nrm_nx;
      fst_q <= fst_nx;
      // Outputs come from next state so they line up with the state edge.
      irq_q <= |(raw_nx & nrm_nx);
      fiq_q <= |(raw_nx & fst_nx);
    end
  end

  assign raw_o      = raw_q;
  assign nrm_mask_o = nrm_q;
  assign fst_mask_o = fst_q;
  assign irq_o      = irq_q;
  assign fiq_o      = fiq_q;

endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_i,
  input  rsel_e                rsel_i,
  input  logic [NUM_LINES-1:0] raw_i,
  input  logic [NUM_LINES-1:0] nrm_mask_i,
  input  logic [NUM_LINES-1:0] fst_mask_i,
  output logic [DATA_W-1:0]    rdata_o
);

  logic [DATA_W-1:0] sel_val;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    unique case (rsel_i)
      RSEL_NRM_STAT: sel_val = DATA_W'(raw_i & nrm_mask_i);
      RSEL_RAW:      sel_val = DATA_W'(raw_i);
      RSEL_NRM_MASK: sel_val = DATA_W'(nrm_mask_i);
      RSEL_SW_BIT:   sel_val = DATA_W'(raw_i[0]);
      RSEL_FST_STAT: sel_val = DATA_W'(raw_i & fst_mask_i);
      RSEL_FST_MASK: sel_val = DATA_W'(fst_mask_i);
      default:       sel_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= sel_val;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/irqc_dual.sv
module irqc_dual
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_o,
  output logic                 fiq_o
);

  localparam int unsigned MASK_W = (NUM_LINES < DATA_W) ? NUM_LINES : DATA_W;

  wstb_t                wstb;
  rsel_e                rsel;
  logic [NUM_LINES-1:0] rise, fall;
  logic [NUM_LINES-1:0] raw, nrm_mask, fst_mask;
  logic [NUM_LINES-1:0] wbits;

  assign wbits = NUM_LINES'(bus_wdata[MASK_W-1:0]);

  irqc_line_sync #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (irq_in),
    .rise_o (rise),
    .fall_o (fall)
  );

  irqc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i   (bus_wr),
    .rd_i   (bus_rd),
    .addr_i (bus_addr),
    .wstb_o (wstb),
    .rsel_o (rsel)
  );

  irqc_state #(.NUM_LINES(NUM_LINES)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .wstb_i     (wstb),
    .wbits_i    (wbits),
    .rise_i     (rise),
    .fall_i     (fall),
    .raw_o      (raw),
    .nrm_mask_o (nrm_mask),
    .fst_mask_o (fst_mask),
    .irq_o      (irq_o),
    .fiq_o      (fiq_o)
  );

  irqc_read_mux #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W)) u_rmux (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_i       (bus_rd),
    .rsel_i     (rsel),
    .raw_i      (raw),
    .nrm_mask_i (nrm_mask),
    .fst_mask_i (fst_mask),
    .rdata_o    (bus_rdata)
  );

endmodule

// File: rtl/irqc_dual_chk.sv
module irqc_dual_chk #(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_in,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic                 irq_o,
  input logic                 fiq_o
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_o && !fiq_o && bus_rdata == '0));

  // R5
  nrm_clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(3) && bus_wdata == '1) |=> !irq_o);

  // R5
  fst_clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(11) && bus_wdata == '1) |=> !fiq_o);

  // R7
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !(bus_addr inside {ADDR_W'(0), ADDR_W'(1), ADDR_W'(2), ADDR_W'(4),
                                  ADDR_W'(8), ADDR_W'(9), ADDR_W'(10)}))
    |=> bus_rdata == '0);

  // R2
  nrm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !bus_wr && $stable(irq_in)) |=> $stable(irq_o));

  // R3
  fst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !bus_wr && $stable(irq_in)) |=> $stable(fiq_o));

  // R4
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind irqc_dual irqc_dual_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (.*);

// File: tb/test_irqc_dual.sv
module test_irqc_dual;

  localparam int unsigned NL = 32;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 32;

  localparam logic [1:0] OP_NOP = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [31:0] lines;
    logic        eirq;
    logic        efiq;
    logic [31:0] erd;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    '{OP_RD,  6'd1,  32'h0,        32'h000, 1'b0, 1'b0, 32'h000}, // R4 raw empty
    '{OP_WR,  6'd2,  32'h0F0,      32'h000, 1'b0, 1'b0, 32'h0},   // R5
    '{OP_NOP, 6'd0,  32'h0,        32'h010, 1'b1, 1'b0, 32'h0},   // R8 R2
    '{OP_RD,  6'd0,  32'h0,        32'h010, 1'b1, 1'b0, 32'h010}, // R4
    '{OP_RD,  6'd1,  32'h0,        32'h010, 1'b1, 1'b0, 32'h010}, // R4
    '{OP_WR,  6'd10, 32'h100,      32'h010, 1'b1, 1'b0, 32'h0},   // R5
    '{OP_NOP, 6'd0,  32'h0,        32'h110, 1'b1, 1'b1, 32'h0},   // R3
    '{OP_RD,  6'd8,  32'h0,        32'h110, 1'b1, 1'b1, 32'h100}, // R4
    '{OP_RD,  6'd9,  32'h0,        32'h110, 1'b1, 1'b1, 32'h110}, // R4
    '{OP_RD,  6'd10, 32'h0,        32'h110, 1'b1, 1'b1, 32'h100}, // R4
    '{OP_WR,  6'd3,  32'h010,      32'h110, 1'b0, 1'b1, 32'h0},   // R5 R2
    '{OP_RD,  6'd2,  32'h0,        32'h110, 1'b0, 1'b1, 32'h0E0}, // R5
    '{OP_WR,  6'd11, 32'hFFFFFFFF, 32'h110, 1'b0, 1'b0, 32'h0},   // R5 R3
    '{OP_RD,  6'd10, 32'h0,        32'h110, 1'b0, 1'b0, 32'h000}, // R5
    '{OP_WR,  6'd2,  32'h001,      32'h110, 1'b0, 1'b0, 32'h0},   // R5
    '{OP_WR,  6'd4,  32'hFFFFFFFE, 32'h110, 1'b0, 1'b0, 32'h0},   // R6 bit0 clear
    '{OP_RD,  6'd1,  32'h0,        32'h110, 1'b0, 1'b0, 32'h110}, // R6
    '{OP_WR,  6'd4,  32'h001,      32'h110, 1'b1, 1'b0, 32'h0},   // R6 set
    '{OP_RD,  6'd4,  32'h0,        32'h110, 1'b1, 1'b0, 32'h001}, // R4
    '{OP_NOP, 6'd0,  32'h0,        32'h100, 1'b1, 1'b0, 32'h0},   // R8 bit0 kept
    '{OP_WR,  6'd0,  32'hFFFFFFFF, 32'h100, 1'b1, 1'b0, 32'h0},   // R7
    '{OP_WR,  6'd1,  32'h0,        32'h100, 1'b1, 1'b0, 32'h0},   // R7
    '{OP_WR,  6'd6,  32'hFFFFFFFF, 32'h100, 1'b1, 1'b0, 32'h0},   // R7
    '{OP_RD,  6'd1,  32'h0,        32'h100, 1'b1, 1'b0, 32'h101}, // R7
    '{OP_RD,  6'd2,  32'h0,        32'h100, 1'b1, 1'b0, 32'h0E1}, // R7
    '{OP_RD,  6'd3,  32'h0,        32'h100, 1'b1, 1'b0, 32'h000}, // R7
    '{OP_RD,  6'd5,  32'h0,        32'h100, 1'b1, 1'b0, 32'h000}, // R7
    '{OP_RD,  6'd11, 32'h0,        32'h100, 1'b1, 1'b0, 32'h000}, // R7
    '{OP_RD,  6'd20, 32'h0,        32'h100, 1'b1, 1'b0, 32'h000}, // R7
    '{OP_WR,  6'd5,  32'hFFFFFFFE, 32'h100, 1'b1, 1'b0, 32'h0},   // R6 ignored
    '{OP_WR,  6'd5,  32'h001,      32'h100, 1'b0, 1'b0, 32'h0},   // R6 clear
    '{OP_NOP, 6'd0,  32'h0,        32'h101, 1'b1, 1'b0, 32'h0},   // R8 rise
    '{OP_NOP, 6'd0,  32'h0,        32'h100, 1'b0, 1'b0, 32'h0},   // R8 fall
    '{OP_WR,  6'd5,  32'h001,      32'h101, 1'b0, 1'b0, 32'h0},   // R9 clr beats rise
    '{OP_WR,  6'd4,  32'h001,      32'h100, 1'b1, 1'b0, 32'h0},   // R9 set beats fall
    '{OP_RD,  6'd4,  32'h0,        32'h100, 1'b1, 1'b0, 32'h001}  // R9
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o, fiq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irqc_dual #(.NUM_LINES(NL), .ADDR_W(AW), .DATA_W(DW)) i_irqc_dual (
    .clk, .rst_n, .irq_in, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
    .bus_rdata, .irq_o, .fiq_o
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drives one access for one cycle; returns at the negedge after the edge.
  task automatic access(logic [1:0] op, logic [5:0] addr, logic [31:0] data,
                        logic [31:0] lines);
    @(negedge clk);
    irq_in    = lines;
    bus_wr    = (op == OP_WR);
    bus_rd    = (op == OP_RD);
    bus_addr  = addr;
    bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during reset
    check("R1", "irq in reset", {31'b0, irq_o}, 32'h0);
    check("R1", "fiq in reset", {31'b0, fiq_o}, 32'h0);
    check("R1", "rdata in reset", bus_rdata, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].lines);
      check($sformatf("vec%0d", i), "irq_o", {31'b0, irq_o}, {31'b0, VEC[i].eirq});
      check($sformatf("vec%0d", i), "fiq_o", {31'b0, fiq_o}, {31'b0, VEC[i].efiq});
      if (VEC[i].op == OP_RD)
        check($sformatf("vec%0d", i), "rdata", bus_rdata, VEC[i].erd);
    end

    // R1: reset mid-run clears masks and raw level
    @(negedge clk);
    irq_in = '0;
    rst_n  = 1'b0;
    @(negedge clk);
    check("R1", "irq after reset", {31'b0, irq_o}, 32'h0);
    check("R1", "rdata after reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    access(OP_RD, 6'd1, 32'h0, 32'h0);
    check("R1", "raw after reset", bus_rdata, 32'h0);
    access(OP_RD, 6'd2, 32'h0, 32'h0);
    check("R1", "nrm mask after reset", bus_rdata, 32'h0);
    access(OP_RD, 6'd10, 32'h0, 32'h0);
    check("R1", "fst mask after reset", bus_rdata, 32'h0);

    // R8 R2: walk every line with the normal mask fully enabled
    access(OP_WR, 6'd2, 32'hFFFFFFFF, 32'h0);
    for (int b = 0; b < NL; b++) begin
      access(OP_NOP, 6'd0, 32'h0, 32'h1 << b);
      check("R2", $sformatf("irq line %0d", b), {31'b0, irq_o}, 32'h1);
      check("R3", $sformatf("fiq line %0d", b), {31'b0, fiq_o}, 32'h0);
      access(OP_RD, 6'd1, 32'h0, 32'h1 << b);
      check("R8", $sformatf("raw line %0d", b), bus_rdata, 32'h1 << b);
    end
    access(OP_NOP, 6'd0, 32'h0, 32'h0);
    check("R8", "all lines low", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule